// File: doc/BRIEF.md
# Descriptor Table Address and Limit Checker

This block keeps the three pointers that locate a processor's descriptor tables: a global table register, an interrupt table register, and a local table selector together with a hidden copy of the local table's base, limit and access rights. A lookup turns a 16-bit segment selector or an 8-bit interrupt vector into the physical byte address of an 8-byte descriptor. It also reports a fault when any byte of that descriptor lies beyond the table's limit.

Loading the local selector starts a search in the global table for the local table's own descriptor. The block presents the address of that descriptor on a fetch request output. When the descriptor comes back on the fill port, the block stores it in the hidden cache. Later segment lookups with the table-indicator bit set use that cache. The block does not fetch memory itself. It checks no privilege and only presents the cached access byte.

Top module: `dtab_ptr_unit`

## Requirements
- R1: During and after a synchronous active-low reset, all registers read zero, the local cache is invalid, and `lk_rsp_vld` and `ldt_fetch_req` are low.
- R2: A pulse on `gtr_ld` or `itr_ld` stores the 48-bit word (base in bits 47:16, limit in bits 15:0) and shows it on `gtr_q` or `itr_q` from the next cycle on.
- R3: A segment lookup (`lk_kind`=0) with `lk_sel[2]`=0 answers one cycle after `lk_req`, with `lk_rsp_addr` = global base + `lk_sel[15:3]`×8.
- R4: A lookup faults when index×8+7 is greater than the table limit, where the limit is the table size minus one. For example, limit 0x00FF admits indices 0 to 31 and faults at index 32.
- R5: An interrupt lookup (`lk_kind`=1) takes the vector from `lk_sel[7:0]` and ignores `lk_sel[15:8]`. It gives interrupt base + vector×8 and checks the interrupt limit.
- R6: A pulse on `ldt_sel_ld` updates `ldt_sel_q` in the next cycle. In that same cycle it raises `ldt_fetch_req` with the global-table address for index `ldt_sel_wdata[15:3]`, ignores bits 2:0, and flags `ldt_fetch_fault` by the rule of R4.
- R7: After a non-faulting selector load, the next `desc_vld` fills the cache. The limit comes from bits 15:0, the base from {63:56, 39:16}, and the access byte from 47:40. The access byte appears on `ldt_access` and the cache becomes valid.
- R8: A `desc_vld` that arrives with no non-faulting selector load pending is ignored. A faulting selector load cancels any pending fill and leaves the cache unchanged.
- R9: A segment lookup with `lk_sel[2]`=1 uses the cached local base and limit. It faults while the cache is invalid.
- R10: A lookup or selector load sees the table state from before any load or fill in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gtr_ld | input | 1 | Load global table register |
| gtr_wdata | input | 48 | Global base and limit to load |
| gtr_q | output | 48 | Global table register contents |
| itr_ld | input | 1 | Load interrupt table register |
| itr_wdata | input | 48 | Interrupt base and limit to load |
| itr_q | output | 48 | Interrupt table register contents |
| ldt_sel_ld | input | 1 | Load local table selector |
| ldt_sel_wdata | input | 16 | Selector to load |
| ldt_sel_q | output | 16 | Local selector contents |
| ldt_fetch_req | output | 1 | Local descriptor fetch request valid |
| ldt_fetch_addr | output | 32 | Address of the local table's descriptor |
| ldt_fetch_fault | output | 1 | Selector lies beyond the global limit |
| desc_vld | input | 1 | Fetched descriptor valid |
| desc_data | input | 64 | Fetched 8-byte descriptor |
| ldt_access | output | 8 | Cached access byte |
| lk_req | input | 1 | Lookup request |
| lk_kind | input | 1 | 0 segment selector, 1 interrupt vector |
| lk_sel | input | 16 | Selector or vector |
| lk_rsp_vld | output | 1 | Lookup response valid |
| lk_rsp_addr | output | 32 | Descriptor byte address |
| lk_rsp_fault | output | 1 | Limit or invalid-cache fault |

## Verification
Two pairs of events can land in the same cycle. A local-table lookup can coincide with a cache fill, and a global lookup or selector load can coincide with a global register load. The bench drives each pair deliberately, with the new values chosen so that the old and new answers differ in both address and fault. It then judges the response against the pre-edge state that its reference model holds. A mixed pseudo-random phase repeats these collisions many times.

// File: rtl/dtab_pkg.sv
// Package: shared widths, field positions and the lookup-kind encoding for
// the descriptor table pointer unit. Assumes 8-byte descriptors.
package dtab_pkg;
    localparam int ADDR_W     = 32;
    localparam int SEL_W      = 16;
    localparam int LIM_W      = SEL_W;              // limit spans the selector byte range
    localparam int DESC_SHIFT = 3;                  // log2 of descriptor size
    localparam int IDX_W      = SEL_W - DESC_SHIFT;
    localparam int VEC_W      = 8;
    localparam int TI_BIT     = 2;                  // selector table-indicator bit
    localparam int TREG_W     = ADDR_W + LIM_W;
    localparam int DESC_W     = 8 << DESC_SHIFT;
    localparam int ACC_W      = 8;

    typedef enum logic {
        LK_SEG = 1'b0,
        LK_VEC = 1'b1
    } lk_kind_e;
endpackage

// File: rtl/dtab_addr_chk.sv
// Module: descriptor address and limit check. Adds index*8 to the table base
// and faults when the offset of the descriptor's last byte passes the limit.
// Purely combinational; assumes limit = table size - 1.
module dtab_addr_chk
    import dtab_pkg::*;
(
    input  logic [ADDR_W-1:0] base,
    input  logic [LIM_W-1:0]  limit,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr,
    output logic              fault
);
    logic [LIM_W-1:0] last_off;

    // Offset of the first and last byte of the descriptor, then the check.
    always_comb begin
        last_off = {idx, {DESC_SHIFT{1'b1}}};
        addr     = base + ADDR_W'({idx, {DESC_SHIFT{1'b0}}});
        fault    = last_off > limit;
    end
endmodule

// File: rtl/dtab_ldt_cache.sv
// Module: hidden local table cache. Captures base, limit and access byte from a
// fetched descriptor when fill is high. Assumes the caller only fills after
// a non-faulting selector search. Not readable except the access byte.
module dtab_ldt_cache
    import dtab_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill,
    input  logic [DESC_W-1:0] desc,
    output logic [ADDR_W-1:0] base,
    output logic [LIM_W-1:0]  limit,
    output logic [ACC_W-1:0]  access,
    output logic              vld
);
    // Descriptor field split: limit 15:0, base 39:16 and 63:56, access 47:40.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base   <= '0;
            limit  <= '0;
            access <= '0;
            vld    <= 1'b0;
        end else if (fill) begin
            base   <= {desc[63:56], desc[39:16]};
            limit  <= desc[LIM_W-1:0];
            access <= desc[47:40];
            vld    <= 1'b1;
        end
    end

    // R7
    cache_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vld) |-> $past(fill));
    // R8
    cache_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fill |=> ($stable(base) && $stable(limit) && $stable(access)));
endmodule

// File: rtl/dtab_ptr_unit.sv
// Module: descriptor table pointer unit (top). Holds the global and interrupt
// table registers and the local selector, resolves selectors and vectors to
// descriptor addresses with limit faults, and requests the local table's
// descriptor when the selector is loaded. Responses are one cycle after the
// request and use the state from before any same-cycle load.
module dtab_ptr_unit
    import dtab_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gtr_ld,
    input  logic [TREG_W-1:0] gtr_wdata,
    output logic [TREG_W-1:0] gtr_q,
    input  logic              itr_ld,
    input  logic [TREG_W-1:0] itr_wdata,
    output logic [TREG_W-1:0] itr_q,
    input  logic              ldt_sel_ld,
    input  logic [SEL_W-1:0]  ldt_sel_wdata,
    output logic [SEL_W-1:0]  ldt_sel_q,
    output logic              ldt_fetch_req,
    output logic [ADDR_W-1:0] ldt_fetch_addr,
    output logic              ldt_fetch_fault,
    input  logic              desc_vld,
    input  logic [DESC_W-1:0] desc_data,
    output logic [ACC_W-1:0]  ldt_access,
    input  logic              lk_req,
    input  logic              lk_kind,
    input  logic [SEL_W-1:0]  lk_sel,
    output logic              lk_rsp_vld,
    output logic [ADDR_W-1:0] lk_rsp_addr,
    output logic              lk_rsp_fault
);
    logic              pending;
    logic              fill;
    logic [ADDR_W-1:0] c_base;
    logic [LIM_W-1:0]  c_limit;
    logic              c_vld;
    logic [ADDR_W-1:0] lk_base;
    logic [LIM_W-1:0]  lk_limit;
    logic [IDX_W-1:0]  lk_idx;
    logic              lk_miss;
    logic [ADDR_W-1:0] lk_addr;
    logic              lk_fault;
    logic [ADDR_W-1:0] ld_addr;
    logic              ld_fault;

    assign fill = desc_vld && pending;

    // Table register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gtr_q <= '0;
            itr_q <= '0;
        end else begin
            if (gtr_ld) gtr_q <= gtr_wdata;
            if (itr_ld) itr_q <= itr_wdata;
        end
    end

    // Pick the table and index a lookup addresses.
    always_comb begin
        lk_miss = 1'b0;
        if (lk_kind == LK_VEC) begin
            lk_base  = itr_q[TREG_W-1:LIM_W];
            lk_limit = itr_q[LIM_W-1:0];
            lk_idx   = IDX_W'(lk_sel[VEC_W-1:0]);
        end else if (lk_sel[TI_BIT]) begin
            lk_base  = c_base;
            lk_limit = c_limit;
            lk_idx   = lk_sel[SEL_W-1:DESC_SHIFT];
            lk_miss  = !c_vld;
        end else begin
            lk_base  = gtr_q[TREG_W-1:LIM_W];
            lk_limit = gtr_q[LIM_W-1:0];
            lk_idx   = lk_sel[SEL_W-1:DESC_SHIFT];
        end
    end

    dtab_addr_chk u_lk_chk (
        .base  (lk_base),
        .limit (lk_limit),
        .idx   (lk_idx),
        .addr  (lk_addr),
        .fault (lk_fault)
    );

    dtab_addr_chk u_ld_chk (
        .base  (gtr_q[TREG_W-1:LIM_W]),
        .limit (gtr_q[LIM_W-1:0]),
        .idx   (ldt_sel_wdata[SEL_W-1:DESC_SHIFT]),
        .addr  (ld_addr),
        .fault (ld_fault)
    );

    // Register the lookup response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_rsp_vld   <= 1'b0;
            lk_rsp_addr  <= '0;
            lk_rsp_fault <= 1'b0;
        end else begin
            lk_rsp_vld <= lk_req;
            if (lk_req) begin
                lk_rsp_addr  <= lk_addr;
                lk_rsp_fault <= lk_fault || lk_miss;
            end
        end
    end

    // Local selector load: store selector, issue fetch, track the pending fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ldt_sel_q       <= '0;
            ldt_fetch_req   <= 1'b0;
            ldt_fetch_addr  <= '0;
            ldt_fetch_fault <= 1'b0;
            pending         <= 1'b0;
        end else begin
            ldt_fetch_req <= ldt_sel_ld;
            if (ldt_sel_ld) begin
                ldt_sel_q       <= ldt_sel_wdata;
                ldt_fetch_addr  <= ld_addr;
                ldt_fetch_fault <= ld_fault;
                pending         <= !ld_fault;
            end else if (fill) begin
                pending <= 1'b0;
            end
        end
    end

    dtab_ldt_cache u_cache (
        .clk    (clk),
        .rst_n  (rst_n),
        .fill   (fill),
        .desc   (desc_data),
        .base   (c_base),
        .limit  (c_limit),
        .access (ldt_access),
        .vld    (c_vld)
    );

    // R2
    treg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gtr_ld |=> (gtr_q == $past(gtr_wdata)));
    // R3
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> lk_rsp_vld);
    // R6
    sel_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ldt_sel_ld |=> (ldt_fetch_req && ldt_sel_q == $past(ldt_sel_wdata)));
    // R8
    fault_no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ldt_fetch_req && ldt_fetch_fault) |-> !pending);
    // R9
    ldt_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_rsp_vld && !lk_rsp_fault && $past(lk_kind == LK_SEG && lk_sel[TI_BIT]))
            |-> $past(c_vld));
endmodule

// File: tb/dtab_ptr_unit_tb.sv
`timescale 1ns/1ps
module dtab_ptr_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gtr_ld = 0, itr_ld = 0, ldt_sel_ld = 0, desc_vld = 0, lk_req = 0, lk_kind = 0;
    logic [47:0] gtr_wdata = '0, itr_wdata = '0;
    logic [15:0] ldt_sel_wdata = '0, lk_sel = '0;
    logic [63:0] desc_data = '0;
    logic [47:0] gtr_q, itr_q;
    logic [15:0] ldt_sel_q;
    logic        ldt_fetch_req, ldt_fetch_fault, lk_rsp_vld, lk_rsp_fault;
    logic [31:0] ldt_fetch_addr, lk_rsp_addr;
    logic [7:0]  ldt_access;

    int    vectors = 0, miscompares = 0;
    bit    started = 0, done = 0;
    string phase = "R1";

    always #4 clk = ~clk;

    dtab_ptr_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .gtr_ld(gtr_ld), .gtr_wdata(gtr_wdata), .gtr_q(gtr_q),
        .itr_ld(itr_ld), .itr_wdata(itr_wdata), .itr_q(itr_q),
        .ldt_sel_ld(ldt_sel_ld), .ldt_sel_wdata(ldt_sel_wdata), .ldt_sel_q(ldt_sel_q),
        .ldt_fetch_req(ldt_fetch_req), .ldt_fetch_addr(ldt_fetch_addr),
        .ldt_fetch_fault(ldt_fetch_fault),
        .desc_vld(desc_vld), .desc_data(desc_data), .ldt_access(ldt_access),
        .lk_req(lk_req), .lk_kind(lk_kind), .lk_sel(lk_sel),
        .lk_rsp_vld(lk_rsp_vld), .lk_rsp_addr(lk_rsp_addr), .lk_rsp_fault(lk_rsp_fault)
    );

    // Reference model state
    logic [47:0] m_gtr, m_itr;
    logic [15:0] m_sel;
    logic [31:0] m_cbase, m_raddr, m_faddr;
    logic [15:0] m_climit;
    logic [7:0]  m_cacc;
    bit          m_cvld, m_pend, m_rvld, m_rfault, m_freq, m_ffault;

    function automatic bit over(input int idx, input logic [15:0] lim);
        return (idx * 8 + 7) > int'(lim);
    endfunction

    function automatic logic [63:0] mk_desc(input logic [31:0] b, input logic [15:0] l,
                                            input logic [7:0] a);
        return {b[31:24], 8'h00, a, b[23:0], l};
    endfunction

    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_gtr = 0; m_itr = 0; m_sel = 0; m_cbase = 0; m_climit = 0; m_cacc = 0;
            m_cvld = 0; m_pend = 0; m_rvld = 0; m_rfault = 0; m_raddr = 0;
            m_freq = 0; m_faddr = 0; m_ffault = 0;
        end else begin
            automatic int idx;
            automatic bit fill = desc_vld && m_pend;
            // lookup against old state
            m_rvld = lk_req;
            if (lk_req) begin
                if (lk_kind) begin
                    idx = int'(lk_sel[7:0]);
                    m_raddr = m_itr[47:16] + 32'(idx * 8);
                    m_rfault = over(idx, m_itr[15:0]);
                end else if (lk_sel[2]) begin
                    idx = int'(lk_sel[15:3]);
                    m_raddr = m_cbase + 32'(idx * 8);
                    m_rfault = !m_cvld || over(idx, m_climit);
                end else begin
                    idx = int'(lk_sel[15:3]);
                    m_raddr = m_gtr[47:16] + 32'(idx * 8);
                    m_rfault = over(idx, m_gtr[15:0]);
                end
            end
            m_freq = ldt_sel_ld;
            if (fill) begin
                m_cbase = {desc_data[63:56], desc_data[39:16]};
                m_climit = desc_data[15:0];
                m_cacc = desc_data[47:40];
                m_cvld = 1;
                m_pend = 0;
            end
            if (ldt_sel_ld) begin
                idx = int'(ldt_sel_wdata[15:3]);
                m_sel = ldt_sel_wdata;
                m_faddr = m_gtr[47:16] + 32'(idx * 8);
                m_ffault = over(idx, m_gtr[15:0]);
                m_pend = !m_ffault;
            end
            if (gtr_ld) m_gtr = gtr_wdata;
            if (itr_ld) m_itr = itr_wdata;
        end
    end

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Compare every output on every falling edge.
    always @(negedge clk) begin
        if (started && !done) begin
            check("R2", "gtr_q", 64'(gtr_q), 64'(m_gtr));
            check("R2", "itr_q", 64'(itr_q), 64'(m_itr));
            check("R6", "ldt_sel_q", 64'(ldt_sel_q), 64'(m_sel));
            check("R7", "ldt_access", 64'(ldt_access), 64'(m_cacc));
            check(phase, "lk_rsp_vld", 64'(lk_rsp_vld), 64'(m_rvld));
            if (m_rvld) begin
                check(phase, "lk_rsp_fault", 64'(lk_rsp_fault), 64'(m_rfault));
                if (!m_rfault) check(phase, "lk_rsp_addr", 64'(lk_rsp_addr), 64'(m_raddr));
            end
            check("R6", "ldt_fetch_req", 64'(ldt_fetch_req), 64'(m_freq));
            if (m_freq) begin
                check("R6", "ldt_fetch_fault", 64'(ldt_fetch_fault), 64'(m_ffault));
                if (!m_ffault) check("R6", "ldt_fetch_addr", 64'(ldt_fetch_addr), 64'(m_faddr));
            end
        end
    end

    task automatic idle();
        gtr_ld = 0; itr_ld = 0; ldt_sel_ld = 0; desc_vld = 0; lk_req = 0;
    endtask

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            idle();
        end
    endtask

    task automatic look(input bit kind, input logic [15:0] s);
        @(negedge clk); idle();
        lk_req = 1; lk_kind = kind; lk_sel = s;
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        rst_n = 1;
        cyc(2);
        // R2 register loads
        phase = "R2";
        @(negedge clk); gtr_ld = 1; gtr_wdata = {32'h0010_0000, 16'h00FF};
        itr_ld = 1; itr_wdata = {32'h0000_8000, 16'h07FF};
        cyc(2);
        // R3 global lookups; R4 limit edge
        phase = "R3";
        look(0, 16'h0000); look(0, 16'h0013); look(0, {13'd31, 3'b011});
        phase = "R4";
        look(0, {13'd32, 3'b000}); look(0, 16'hFFF8); cyc(2);
        // R5 interrupt vectors, upper bits ignored
        phase = "R5";
        look(1, 16'h0000); look(1, 16'hA5FF); look(1, 16'h3C20);
        @(negedge clk); idle(); itr_ld = 1; itr_wdata = {32'h0000_8000, 16'h00FF};
        look(1, 16'h001F); look(1, 16'h0020); cyc(2);
        // R9 local lookup with invalid cache
        phase = "R9";
        look(0, 16'h0004); cyc(2);
        // R6 selector load, R7 fill
        phase = "R7";
        @(negedge clk); idle(); ldt_sel_ld = 1; ldt_sel_wdata = 16'h0013;
        cyc(2);
        @(negedge clk); desc_vld = 1; desc_data = mk_desc(32'h1234_5600, 16'h003F, 8'h82);
        look(0, {13'd7, 3'b100}); look(0, {13'd8, 3'b100}); look(0, 16'h0004); cyc(2);
        // R8 faulting selector, stray descriptor
        phase = "R8";
        @(negedge clk); idle(); ldt_sel_ld = 1; ldt_sel_wdata = {13'd40, 3'b000};
        @(negedge clk); idle(); desc_vld = 1; desc_data = mk_desc(32'hDEAD_0000, 16'hFFFF, 8'h11);
        @(negedge clk); idle(); desc_vld = 1;
        look(0, {13'd7, 3'b100}); look(0, {13'd100, 3'b100}); cyc(2);
        // R10 same-cycle fill and local lookup; global load and lookup/selector
        phase = "R10";
        @(negedge clk); idle(); ldt_sel_ld = 1; ldt_sel_wdata = 16'h0008;
        cyc(1);
        @(negedge clk); desc_vld = 1; desc_data = mk_desc(32'h0040_0000, 16'h0FFF, 8'h93);
        lk_req = 1; lk_kind = 0; lk_sel = {13'd50, 3'b100};
        look(0, {13'd50, 3'b100});
        @(negedge clk); idle(); gtr_ld = 1; gtr_wdata = {32'h0200_0000, 16'h0007};
        lk_req = 1; lk_kind = 0; lk_sel = {13'd20, 3'b000};
        ldt_sel_ld = 1; ldt_sel_wdata = {13'd20, 3'b000};
        look(0, {13'd20, 3'b000}); cyc(2);
        // mixed pseudo-random traffic
        for (int i = 0; i < 400; i++) begin
            @(negedge clk); idle();
            gtr_ld = ($urandom % 8) == 0;
            gtr_wdata = {$urandom, 16'($urandom % 512)};
            itr_ld = ($urandom % 8) == 0;
            itr_wdata = {$urandom, 16'($urandom % 2048)};
            ldt_sel_ld = ($urandom % 6) == 0;
            ldt_sel_wdata = 16'($urandom % 512);
            desc_vld = ($urandom % 3) == 0;
            desc_data = {$urandom, $urandom} & 64'hFF00_FFFF_FFFF_03FF;
            lk_req = ($urandom % 2) == 0;
            lk_kind = 1'($urandom);
            lk_sel = 16'($urandom % 1024);
        end
        cyc(3);
        finish_run();
    end
endmodule